// File: doc/BRIEF.md
# SPI Flash Cycle Sequencer

The sequencer runs one serial flash transaction each time host software sets a go bit in its control register. Before that, software fills a small register set. An eight-slot menu holds the opcode bytes. A two-slot table holds the prefix opcodes. A type word gives each menu slot two bits. A 24-bit address register and a 64-byte data buffer complete the set. The control word picks a menu slot, a prefix slot, a byte count, and whether the cycle carries data and is atomic.

During a cycle the engine drives the chip select, serial clock and data pins itself. With the atomic bit set, it first sends a one-byte frame that carries the selected prefix opcode, such as a write enable. It then raises chip select for at least one serial clock period. The main frame follows: the menu opcode, then a three-byte address if the slot's type calls for one, then the data bytes. For slots of the write class the data bytes come out of the buffer. For every other slot the returned bytes are stored in the buffer. The status word reports the cycle as in progress, done or blocked. A separate protection block can refuse a cycle through `deny_i`.

Top module: `spi_cycle_seq`

## Requirements
- R1: After reset every register reads zero, `cs_no` is high and `sclk_o` is low.
- R2: A control write with bit 1 (go) set starts a cycle, and status bit 0 (in progress) reads 1 right after that write. When the cycle finishes, bit 0 clears and bit 2 (done) sets. `irq_o` is high while control bit 15 and done are both set.
- R3: The serial interface uses mode 0. `sclk_o` is low whenever `cs_no` is high. Bits go out MSB first and change only while the clock is low. The first byte of the main frame is the menu entry picked by control bits 6:4.
- R4: The type word gives menu entry i the bits 2i+1:2i. When bit 1 of the pair is set, the three address bytes follow the opcode, most significant byte first. When it is clear, no address is sent.
- R5: When control bit 14 is set, the main frame carries control bits 13:8 plus one data bytes, from 1 to 64. When bit 14 is clear, it carries none.
- R6: For a write-class entry (bit 0 of its type pair set), the data bytes are sent from buffer byte 0 upward and the buffer is left unchanged. For other entries the engine sends 0x00 and stores the received bytes from buffer byte 0 upward.
- R7: With control bit 2 (atomic) set, a frame that carries only the prefix picked by control bit 3 comes first. Chip select stays high for at least one serial clock period before the main frame starts.
- R8: Status bits 2 and 3 are cleared by writing 1 to them. Writing 0 leaves them as they are.
- R9: While a cycle is in progress, every register write except the status clear is ignored.
- R10: If `deny_i` is high when go is written, no frame is sent, in progress stays 0, and status bits 3 (blocked) and 2 (done) set.
- R11: The word offsets are fixed. Control is at 0x00 and reads bit 1 and bit 7 as 0. Status is at 0x01. Address bits 15:0 are at 0x02 and bits 23:16 are at 0x03. The type word is at 0x04. The prefix pair {slot1, slot0} is at 0x05. Menu pairs {slot 2k+1, slot 2k} are at 0x08+k. Buffer pairs {byte 2k+1, byte 2k} are at 0x20+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Register write word offset |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 6 | Register read word offset |
| rd_data_o | output | 16 | Register read data (combinational) |
| deny_i | input | 1 | Protection block refuses the cycle being started |
| irq_o | output | 1 | Cycle-end interrupt request |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to flash |
| miso_i | input | 1 | Serial data from flash |

## Verification
The bench sends read-ID, addressed read, bare status read, atomic program and atomic status write cycles to a behavioural flash model, and compares every frame byte for byte. A design that put the address on the wall without checking the type pair would add stray bytes. A design that sent write data in the wrong direction would corrupt the buffer on a program cycle. The full 64-byte read checks that the count is not off by one and that buffer byte 63 is written. The bench also counts the clocks of the chip-select gap between the prefix frame and the main frame, and confirms that writes made during a cycle, and a denied go, leave no trace on the wires or in the registers.

// File: rtl/spi_seq_pkg.sv
`timescale 1ns/1ps
package spi_seq_pkg;
  localparam int MENU_N = 8;
  localparam int PFX_N  = 2;
  localparam int BUF_N  = 64;
  localparam int ADR_W  = 24;
  localparam int RA_W   = 6;
  localparam int BUF_AW = $clog2(BUF_N);
  localparam int SEL_W  = $clog2(MENU_N);
  localparam int IDX_W  = BUF_AW + 1;

  localparam logic [RA_W-1:0] A_CTRL = 6'h00;
  localparam logic [RA_W-1:0] A_STAT = 6'h01;
  localparam logic [RA_W-1:0] A_ADRL = 6'h02;
  localparam logic [RA_W-1:0] A_ADRH = 6'h03;
  localparam logic [RA_W-1:0] A_TYPE = 6'h04;
  localparam logic [RA_W-1:0] A_PFX  = 6'h05;

  localparam int C_IRQ  = 15;
  localparam int C_DAT  = 14;
  localparam int C_CNT  = 8;
  localparam int C_OP   = 4;
  localparam int C_PSEL = 3;
  localparam int C_ATOM = 2;
  localparam int C_GO   = 1;
  localparam logic [15:0] CTRL_MASK = 16'hFF7D;

  localparam int S_BUSY = 0;
  localparam int S_DONE = 2;
  localparam int S_BLK  = 3;

  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_BYTE, ST_WAIT, ST_GAP} seq_st_e;

  typedef struct packed {
    logic              has_data;
    logic [BUF_AW-1:0] cnt;
    logic              has_addr;
    logic              is_wr;
    logic              atomic;
  } frame_cfg_t;
endpackage

// File: rtl/spi_tick_gen.sv
`timescale 1ns/1ps
module spi_tick_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  generate
    if (HALF_DIV <= 1) begin : g_pass
      assign tick_o = en_i;
    end else begin : g_div
      localparam int CW = $clog2(HALF_DIV);
      localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           cnt_q <= '0;
        else if (!en_i)        cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = en_i && (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/spi_byte_shift.sv
`timescale 1ns/1ps
module spi_byte_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  logic       act_q, sclk_q, done_q;
  logic [7:0] sh_q, rx_q;
  logic [3:0] hc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0; sclk_q <= 1'b0; done_q <= 1'b0;
      sh_q <= '0; rx_q <= '0; hc_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        act_q <= 1'b1; sh_q <= tx_i; hc_q <= '0; sclk_q <= 1'b0;
      end else if (act_q && tick_i) begin
        if (!hc_q[0]) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[6:0], miso_i};
        end else begin
          sclk_q <= 1'b0;
          sh_q   <= {sh_q[6:0], 1'b0};
        end
        hc_q <= hc_q + 1'b1;
        if (hc_q == 4'd15) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = sh_q[7];
  assign busy_o = act_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;

  // R3
  byte_end_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !sclk_q);
endmodule

// File: rtl/spi_seq_fsm.sv
`timescale 1ns/1ps
module spi_seq_fsm
  import spi_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  frame_cfg_t        cfg_i,
  input  logic              tick_i,
  input  logic              sh_done_i,
  input  logic [7:0]        sh_rx_i,
  input  logic [7:0]        opcode_i,
  input  logic [7:0]        prefix_i,
  input  logic [ADR_W-1:0]  addr_i,
  input  logic [7:0]        buf_rd_i,
  output logic              tick_en_o,
  output logic              sh_start_o,
  output logic [7:0]        sh_tx_o,
  output logic [BUF_AW-1:0] buf_idx_o,
  output logic              buf_we_o,
  output logic [7:0]        buf_wdata_o,
  output logic              cs_no,
  output logic              busy_o,
  output logic              fin_o
);
  seq_st_e          st_q;
  logic             in_pre_q, last_q, gap_q, cs_n_q;
  logic [IDX_W-1:0] idx_q, n_addr, n_data, last_idx, dk;
  logic             is_last, is_data;

  assign n_addr   = cfg_i.has_addr ? IDX_W'(3) : '0;
  assign n_data   = cfg_i.has_data ? IDX_W'(cfg_i.cnt) + 1'b1 : '0;
  assign last_idx = n_addr + n_data;
  assign is_last  = in_pre_q || (idx_q == last_idx);
  assign is_data  = !in_pre_q && (idx_q > n_addr);
  assign dk       = idx_q - IDX_W'(1) - n_addr;
  assign buf_idx_o = dk[BUF_AW-1:0];

  always_comb begin
    if (in_pre_q)                          sh_tx_o = prefix_i;
    else if (idx_q == '0)                  sh_tx_o = opcode_i;
    else if (cfg_i.has_addr && idx_q <= IDX_W'(3)) begin
      case (idx_q[1:0])
        2'd1:    sh_tx_o = addr_i[23:16];
        2'd2:    sh_tx_o = addr_i[15:8];
        default: sh_tx_o = addr_i[7:0];
      endcase
    end
    else if (cfg_i.is_wr)                  sh_tx_o = buf_rd_i;
    else                                   sh_tx_o = 8'h00;
  end

  assign tick_en_o   = (st_q != ST_IDLE);
  assign sh_start_o  = tick_i && ((st_q == ST_SETUP) || (st_q == ST_WAIT && !last_q));
  assign fin_o       = (st_q == ST_WAIT) && tick_i && last_q && !in_pre_q;
  assign buf_we_o    = (st_q == ST_BYTE) && sh_done_i && is_data && !cfg_i.is_wr;
  assign buf_wdata_o = sh_rx_i;
  assign cs_no       = cs_n_q;
  assign busy_o      = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; in_pre_q <= 1'b0; last_q <= 1'b0;
      gap_q <= 1'b0; cs_n_q <= 1'b1; idx_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (go_i) begin
          cs_n_q <= 1'b0; in_pre_q <= cfg_i.atomic; idx_q <= '0; st_q <= ST_SETUP;
        end
        ST_SETUP: if (tick_i) st_q <= ST_BYTE;
        ST_BYTE: if (sh_done_i) begin
          last_q <= is_last; idx_q <= idx_q + 1'b1; st_q <= ST_WAIT;
        end
        ST_WAIT: if (tick_i) begin
          if (last_q) begin
            cs_n_q <= 1'b1;
            if (in_pre_q) begin
              in_pre_q <= 1'b0; idx_q <= '0; gap_q <= 1'b0; st_q <= ST_GAP;
            end else st_q <= ST_IDLE;
          end else st_q <= ST_BYTE;
        end
        ST_GAP: if (tick_i) begin
          if (gap_q) begin
            cs_n_q <= 1'b0; st_q <= ST_SETUP;
          end else gap_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  shift_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_done_i |-> (st_q == ST_BYTE));
  // R2
  fin_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> (!busy_o && cs_no));
  // R7
  gap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_GAP && !(tick_i && gap_q)) |=> cs_no);
endmodule

// File: rtl/spi_cycle_seq.sv
`timescale 1ns/1ps
module spi_cycle_seq
  import spi_seq_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [5:0]  wr_addr_i,
  input  logic [15:0] wr_data_i,
  input  logic [5:0]  rd_addr_i,
  output logic [15:0] rd_data_o,
  input  logic        deny_i,
  output logic        irq_o,
  output logic        sclk_o,
  output logic        cs_no,
  output logic        mosi_o,
  input  logic        miso_i
);
  logic [15:0]      ctrl_q, type_q;
  logic [ADR_W-1:0] addr_q;
  logic [7:0]       pfx_q  [PFX_N];
  logic [7:0]       menu_q [MENU_N];
  logic [7:0]       buf_q  [BUF_N];
  logic             done_q, blk_q, go_pend_q;

  logic busy, fsm_busy, wr_ok, go_req, blk_ev, fin;
  logic tick, tick_en, sh_start, sh_done, sh_busy;
  logic [7:0] sh_tx, sh_rx, fsm_wdata;
  logic [BUF_AW-1:0] fsm_idx;
  logic fsm_we;
  logic [SEL_W-1:0] op_sel;
  logic [1:0] ty;
  frame_cfg_t cfg;

  assign busy   = fsm_busy || go_pend_q;
  assign wr_ok  = wr_en_i && !busy;
  assign go_req = wr_ok && (wr_addr_i == A_CTRL) && wr_data_i[C_GO];
  assign blk_ev = go_req && deny_i;

  assign op_sel       = ctrl_q[C_OP +: SEL_W];
  assign ty           = type_q[{op_sel, 1'b0} +: 2];
  assign cfg.has_data = ctrl_q[C_DAT];
  assign cfg.cnt      = ctrl_q[C_CNT +: BUF_AW];
  assign cfg.has_addr = ty[1];
  assign cfg.is_wr    = ty[0];
  assign cfg.atomic   = ctrl_q[C_ATOM];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0; type_q <= '0; addr_q <= '0; go_pend_q <= 1'b0;
      for (int i = 0; i < PFX_N; i++)  pfx_q[i]  <= '0;
      for (int i = 0; i < MENU_N; i++) menu_q[i] <= '0;
    end else begin
      go_pend_q <= go_req && !deny_i;
      if (wr_ok) begin
        case (wr_addr_i)
          A_CTRL: ctrl_q <= wr_data_i & CTRL_MASK;
          A_ADRL: addr_q[15:0] <= wr_data_i;
          A_ADRH: addr_q[23:16] <= wr_data_i[7:0];
          A_TYPE: type_q <= wr_data_i;
          A_PFX:  begin pfx_q[0] <= wr_data_i[7:0]; pfx_q[1] <= wr_data_i[15:8]; end
          default: ;
        endcase
        if (wr_addr_i[5:2] == 4'b0010)
          for (int i = 0; i < MENU_N; i++)
            if (wr_addr_i[1:0] == 2'(i >> 1))
              menu_q[i] <= i[0] ? wr_data_i[15:8] : wr_data_i[7:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BUF_N; i++) buf_q[i] <= '0;
    end else begin
      for (int i = 0; i < BUF_N; i++) begin
        if (wr_ok && wr_addr_i[5] && wr_addr_i[4:0] == 5'(i >> 1))
          buf_q[i] <= i[0] ? wr_data_i[15:8] : wr_data_i[7:0];
        else if (fsm_we && fsm_idx == BUF_AW'(i))
          buf_q[i] <= fsm_wdata;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0; blk_q <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == A_STAT && wr_data_i[S_DONE]) done_q <= 1'b0;
      if (wr_en_i && wr_addr_i == A_STAT && wr_data_i[S_BLK])  blk_q  <= 1'b0;
      if (fin || blk_ev) done_q <= 1'b1;
      if (blk_ev)        blk_q  <= 1'b1;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i[5])
      rd_data_o = {buf_q[{rd_addr_i[4:0], 1'b1}], buf_q[{rd_addr_i[4:0], 1'b0}]};
    else if (rd_addr_i[5:2] == 4'b0010)
      rd_data_o = {menu_q[{rd_addr_i[1:0], 1'b1}], menu_q[{rd_addr_i[1:0], 1'b0}]};
    else begin
      case (rd_addr_i)
        A_CTRL: rd_data_o = ctrl_q;
        A_STAT: rd_data_o = {12'd0, blk_q, done_q, 1'b0, busy};
        A_ADRL: rd_data_o = addr_q[15:0];
        A_ADRH: rd_data_o = {8'd0, addr_q[23:16]};
        A_TYPE: rd_data_o = type_q;
        A_PFX:  rd_data_o = {pfx_q[1], pfx_q[0]};
        default: rd_data_o = '0;
      endcase
    end
  end

  assign irq_o = ctrl_q[C_IRQ] && done_q;

  spi_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(tick_en), .tick_o(tick));

  spi_byte_shift u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .start_i(sh_start),
    .tx_i(sh_tx), .miso_i(miso_i), .sclk_o(sclk_o), .mosi_o(mosi_o),
    .busy_o(sh_busy), .done_o(sh_done), .rx_o(sh_rx));

  spi_seq_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go_pend_q), .cfg_i(cfg),
    .tick_i(tick), .sh_done_i(sh_done), .sh_rx_i(sh_rx),
    .opcode_i(menu_q[op_sel]), .prefix_i(pfx_q[ctrl_q[C_PSEL]]),
    .addr_i(addr_q), .buf_rd_i(buf_q[fsm_idx]),
    .tick_en_o(tick_en), .sh_start_o(sh_start), .sh_tx_o(sh_tx),
    .buf_idx_o(fsm_idx), .buf_we_o(fsm_we), .buf_wdata_o(fsm_wdata),
    .cs_no(cs_no), .busy_o(fsm_busy), .fin_o(fin));

  // R3
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  // R3
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_start |-> !sh_busy);
  // R2
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(go_req));
  // R9
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(ctrl_q));
  // R8
  done_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_STAT && wr_data_i[S_DONE] && !fin && !blk_ev) |=> !done_q);
  // R10
  blk_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_ev |=> (blk_q && done_q && !busy));
endmodule

// File: tb/spi_cycle_seq_bench.sv
`timescale 1ns/1ps
module spi_cycle_seq_bench;
  localparam int HALF = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, deny = 1'b0;
  logic [5:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic irq, sclk, cs_n, mosi, miso;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 1'b0, exp_active = 1'b0, seen_frame = 1'b0;
  logic [7:0] log_b[$];
  int         log_len[$];
  logic [7:0] cur_b[$];
  logic [7:0] cap;
  int cap_bits = 0, out_bits = 0, rise_cyc = 0, last_gap = 0;
  logic [7:0] exp_b[$];
  int         exp_len[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  spi_cycle_seq #(.HALF_DIV(HALF)) u_spi_cycle_seq (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .deny_i(deny), .irq_o(irq), .sclk_o(sclk), .cs_no(cs_n),
    .mosi_o(mosi), .miso_i(miso));

  // behavioural flash: answers byte j of a frame with 0x5A ^ j
  always_comb begin
    logic [7:0] rb;
    rb = 8'h5A ^ 8'(out_bits / 8);
    miso = cs_n ? 1'b0 : rb[7 - (out_bits % 8)];
  end
  always @(negedge cs_n) begin
    if (seen_frame) last_gap = cyc - rise_cyc;
    seen_frame = 1'b1; cap_bits = 0; out_bits = 0; cur_b.delete();
  end
  always @(posedge cs_n) if (seen_frame) begin
    log_len.push_back(cur_b.size());
    foreach (cur_b[k]) log_b.push_back(cur_b[k]);
    rise_cyc = cyc;
  end
  always @(posedge sclk) if (cs_n === 1'b0) begin
    cap = {cap[6:0], mosi}; cap_bits++;
    if (cap_bits == 8) begin cur_b.push_back(cap); cap_bits = 0; end
  end
  always @(negedge sclk) if (cs_n === 1'b0) out_bits++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // per-clock model: idle clock in mode 0, and no frame unless a cycle was launched
  always @(negedge clk) if (rst_n && !finished) begin
    checks++;
    if ((cs_n && sclk) || (!exp_active && !cs_n)) begin
      fails++;
      $display("FAIL R3/R10 act=cs%0b_sclk%0b exp=idle_low active=%0b", cs_n, sclk, exp_active);
    end
  end

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); rd_addr = a; #1; d = rd_data;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int n = 0; n < 20000; n++) begin
      rd(6'h01, s);
      if (!s[0]) break;
    end
    repeat (3) @(negedge clk);
    exp_active = 1'b0;
  endtask

  task automatic launch(input logic [15:0] c, input string req);
    logic [15:0] s;
    exp_active = 1'b1;
    wr(6'h00, c);
    rd(6'h01, s);
    chk({req, " in_progress"}, s[0], 1);
  endtask

  task automatic add_frame(input logic [7:0] b[$]);
    exp_len.push_back(b.size());
    foreach (b[k]) exp_b.push_back(b[k]);
  endtask

  task automatic cmp_frames(input string req);
    chk({req, " frame_count"}, log_len.size(), exp_len.size());
    if (log_len.size() == exp_len.size()) begin
      foreach (exp_len[k]) chk({req, " frame_len"}, log_len[k], exp_len[k]);
      if (log_b.size() == exp_b.size())
        foreach (exp_b[k]) chk({req, " frame_byte"}, log_b[k], exp_b[k]);
    end
    log_b.delete(); log_len.delete(); exp_b.delete(); exp_len.delete();
  endtask

  initial begin
    logic [15:0] d;
    logic [7:0] fr[$];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(6'h00, d); chk("R1 ctrl", d, 0);
    rd(6'h01, d); chk("R1 status", d, 0);
    rd(6'h20, d); chk("R1 buffer", d, 0);
    chk("R1 cs_n", cs_n, 1);
    chk("R1 sclk", sclk, 0);

    // R11 program tables and read back
    wr(6'h08, 16'h0B03); wr(6'h09, 16'h9F05);
    wr(6'h0A, 16'h2002); wr(6'h0B, 16'h01D8);
    wr(6'h05, 16'h0650); wr(6'h04, 16'h7F0A);
    rd(6'h09, d); chk("R11 menu pair", d, 16'h9F05);
    rd(6'h0B, d); chk("R11 menu pair hi", d, 16'h01D8);
    rd(6'h05, d); chk("R11 prefix pair", d, 16'h0650);
    rd(6'h04, d); chk("R11 type word", d, 16'h7F0A);

    // R5 R6 read ID: 3 bytes received
    launch(16'h4233, "R2");
    wait_idle();
    rd(6'h01, d); chk("R2 done status", d, 16'h0004);
    rd(6'h00, d); chk("R11 ctrl go reads 0", d, 16'h4231);
    fr = '{8'h9F, 8'h00, 8'h00, 8'h00}; add_frame(fr);
    cmp_frames("R6 read id");
    rd(6'h20, d); chk("R6 rx bytes 0-1", d, 16'h585B);
    rd(6'h21, d); chk("R5 rx byte 2 only", d, 16'h0059);
    wr(6'h01, 16'h0000);
    rd(6'h01, d); chk("R8 write zero keeps done", d, 16'h0004);
    wr(6'h01, 16'h0004);
    rd(6'h01, d); chk("R8 done cleared", d, 0);

    // R4 addressed read, 1 byte
    wr(6'h02, 16'h3456); wr(6'h03, 16'h0012);
    launch(16'h4003, "R4");
    wait_idle();
    fr = '{8'h03, 8'h12, 8'h34, 8'h56, 8'h00}; add_frame(fr);
    cmp_frames("R4 addr msb first");
    rd(6'h20, d); chk("R5 single byte stored", d, 16'h585E);
    wr(6'h01, 16'h0004);

    // R5 no data, no address
    launch(16'h0023, "R5");
    wait_idle();
    fr = '{8'h05}; add_frame(fr);
    cmp_frames("R5 no data");
    rd(6'h20, d); chk("R5 buffer untouched", d, 16'h585E);
    wr(6'h01, 16'h0004);

    // R7 R6 atomic page program
    wr(6'h20, 16'h2211); wr(6'h21, 16'h4433);
    wr(6'h02, 16'hABCD); wr(6'h03, 16'h0000);
    launch(16'h434F, "R7");
    wait_idle();
    fr = '{8'h06}; add_frame(fr);
    fr = '{8'h02, 8'h00, 8'hAB, 8'hCD, 8'h11, 8'h22, 8'h33, 8'h44}; add_frame(fr);
    cmp_frames("R7 prefix then program");
    chk("R7 gap >= one sclk", (last_gap >= 2 * HALF) ? 1 : 0, 1);
    rd(6'h20, d); chk("R6 write keeps buffer", d, 16'h2211);
    rd(6'h21, d); chk("R6 write keeps buffer hi", d, 16'h4433);
    wr(6'h01, 16'h0004);

    // R2 interrupt
    launch(16'h8023, "R2");
    wait_idle();
    chk("R2 irq at end", irq, 1);
    wr(6'h01, 16'h0004);
    chk("R2 irq cleared", irq, 0);
    fr = '{8'h05}; add_frame(fr);
    cmp_frames("R2 irq cycle");

    // R9 writes during a 64-byte read are ignored
    launch(16'h7F13, "R9");
    wr(6'h00, 16'h0000);
    wr(6'h03, 16'h00FF);
    wr(6'h20, 16'hEEEE);
    wait_idle();
    rd(6'h00, d); chk("R9 ctrl kept", d, 16'h7F11);
    rd(6'h03, d); chk("R9 addr kept", d, 16'h0000);
    fr = '{8'h0B, 8'h00, 8'hAB, 8'hCD};
    for (int k = 0; k < 64; k++) fr.push_back(8'h00);
    add_frame(fr);
    cmp_frames("R5 64-byte read");
    rd(6'h20, d); chk("R9 buffer holds rx 0-1", d, 16'h5F5E);
    rd(6'h3F, d); chk("R5 rx bytes 62-63", d, 16'h1918);
    rd(6'h01, d); chk("R2 done after long", d, 16'h0004);
    wr(6'h01, 16'h0004);

    // R10 denied go
    @(negedge clk); deny = 1'b1;
    wr(6'h00, 16'h0023);
    deny = 1'b0;
    rd(6'h01, d); chk("R10 blocked+done", d, 16'h000C);
    repeat (40) @(negedge clk);
    cmp_frames("R10 no frame");
    wr(6'h01, 16'h0008);
    rd(6'h01, d); chk("R8 blocked cleared alone", d, 16'h0004);
    wr(6'h01, 16'h0004);

    // R7 R6 atomic status write with prefix slot 0
    wr(6'h20, 16'h0002);
    launch(16'h4077, "R7");
    wait_idle();
    fr = '{8'h50}; add_frame(fr);
    fr = '{8'h01, 8'h02}; add_frame(fr);
    cmp_frames("R7 prefix slot0");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule